// File: doc/BRIEF.md
# Prescaled Triple Interval Timer

This peripheral holds three independent up-counting timer channels behind a small word-addressed register bus. Each channel takes one of two shared tick enables as its time base. An optional power-of-two prescaler can divide that tick stream before it reaches the counter. The channel then counts either freely across its full width or up to a programmable interval value, after which it wraps to zero.

Each channel has one interval event and one overflow event. Both land in a status register that clears itself when software reads it. An enable register masks the events onto one interrupt line per channel. Software can halt a counter in place or restart it from zero with single control bits. This makes the block usable both as a free-running time base and as a periodic or one-off event generator.

The bus has single-cycle write and read strobes, a word address, and write data. Read data is registered and appears in the cycle after the read strobe.

Top module: `trio_timer`

## Requirements
- R1: Word addresses hold the following registers. Channel c (0 to 2) has clock setup at 0+c, counter control at 3+c, count at 6+c, interval at 9+c, status at 21+c and interrupt enable at 24+c. No other channel's state changes when one channel's registers are used.
- R2: After reset the following registers read 0: clock setup, count, interval, status and interrupt enable. Counter control reads 0x21, which means halted. Every interrupt line is low.
- R3: Clock setup bit 0 enables the prescaler and bits 4:1 hold a value N. With bit 0 clear, the count advances once per selected tick. With bit 0 set, it advances once per 2^(N+1) selected ticks.
- R4: Clock setup bit 5 picks the time base: 0 selects tick_a and 1 selects tick_b. The unselected tick has no effect.
- R5: Counter control bit 0 set to 1 halts the channel, and the count holds its value. Clearing the bit lets counting continue from the held value.
- R6: Writing counter control with bit 4 set zeroes the count and the prescaler phase. The bit is not stored and reads back as 0.
- R7: In free-running mode (counter control bit 1 = 0), the count wraps from all ones to 0. That wrap sets status bit 3.
- R8: In interval mode (counter control bit 1 = 1), an advance from a count at or above the interval value gives 0 and sets status bit 0. An interval value of 0 holds the count at 0 and sets no status.
- R9: A read of a status register returns its pending bits and clears them. An event raised in the same cycle as that read stays pending afterwards.
- R10: A channel's interrupt line is high exactly while a status bit is set whose interrupt-enable bit (bit 0 or bit 3) is also set.
- R11: Counter control bits 0, 1 and 5 are stored and read back, while bits 2, 3 and 4 read 0. Bit 5 has no effect on counting. Writes to count or status registers change nothing.
- R12: Read data is valid in the cycle after rd_en and is 0 in any other cycle. Unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_a | input | 1 | First shared tick enable |
| tick_b | input | 1 | Second shared tick enable |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | ADDR_W (5) | Word address |
| wdata | input | DATA_W (32) | Write data |
| rdata | output | DATA_W (32) | Registered read data |
| irq | output | NUM_CH (3) | Per-channel interrupt lines |

## Verification
The bench builds the block with an 8-bit count width, so a full free-running wrap and its overflow flag take only 256 ticks. That width makes complete rollovers and interrupt masking affordable on every channel. The bench runs the same sweep on each of the three channels, over several tick counts, prescaler values 0 to 3 and interval values 0 to 4. Expected counts come from shifts and modulo arithmetic. It also places a status read in the same cycle as an interval event to check the clear-versus-set ordering.

// File: rtl/trio_timer_pkg.sv
package trio_timer_pkg;
  // word-address bases of the register groups, one word per channel
  localparam int GRP_CLK = 0;
  localparam int GRP_CNT = 3;
  localparam int GRP_VAL = 6;
  localparam int GRP_IVL = 9;
  localparam int GRP_STA = 21;
  localparam int GRP_IEN = 24;

  // counter control bit positions
  localparam int CC_HALT    = 0;
  localparam int CC_IMODE   = 1;
  localparam int CC_RESTART = 4;
  localparam int CC_SPARE   = 5;

  // status / enable bit positions
  localparam int ST_IVL = 0;
  localparam int ST_OVF = 3;
  localparam int ST_W   = 4;
endpackage

// File: rtl/trio_prescale.sv
module trio_prescale #(
  parameter int PSV_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic             run,
  input  logic             tick_a,
  input  logic             tick_b,
  input  logic             src_sel,
  input  logic             pre_en,
  input  logic [PSV_W-1:0] psv,
  output logic             adv
);
  localparam int DIV_W = 1 << PSV_W;

  logic             tick;
  logic [PSV_W:0]   shamt;
  logic [DIV_W:0]   lim_w;
  logic [DIV_W-1:0] lim;
  logic [DIV_W-1:0] phase_q;
  logic             wrap;

  assign tick  = src_sel ? tick_b : tick_a;
  assign shamt = {1'b0, psv} + {{PSV_W{1'b0}}, 1'b1};
  assign lim_w = ({{DIV_W{1'b0}}, 1'b1} << shamt) - {{DIV_W{1'b0}}, 1'b1};
  assign lim   = lim_w[DIV_W-1:0];
  assign wrap  = (phase_q == lim);
  assign adv   = tick && run && (!pre_en || wrap);

  always_ff @(posedge clk) begin
    if (rst || clear || !pre_en) begin
      phase_q <= '0;
    end else if (tick && run) begin
      phase_q <= wrap ? '0 : phase_q + 1'b1;
    end
  end

  // R4: the selected tick is the only source of advances
  a_r4_no_tick_no_adv: assert property (@(posedge clk) disable iff (rst)
    !(src_sel ? tick_b : tick_a) |-> !adv);
  // R3: without prescaling every selected tick of a running channel advances
  a_r3_direct_tick: assert property (@(posedge clk) disable iff (rst)
    (run && !pre_en && (src_sel ? tick_b : tick_a)) |-> adv);
endmodule

// File: rtl/trio_channel.sv
module trio_channel
  import trio_timer_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int PSV_W = 4,
  localparam int CLK_W = PSV_W + 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick_a,
  input  logic             tick_b,
  input  logic             wr_clk,
  input  logic             wr_cnt,
  input  logic             wr_ivl,
  input  logic             wr_ien,
  input  logic             rd_sta,
  input  logic [CNT_W-1:0] wdata,
  output logic [CLK_W-1:0] clk_rb,
  output logic [5:0]       cnt_rb,
  output logic [CNT_W-1:0] count,
  output logic [CNT_W-1:0] ivl,
  output logic [ST_W-1:0]  sta,
  output logic [ST_W-1:0]  ien,
  output logic             irq
);
  logic             pre_en_q, src_q;
  logic [PSV_W-1:0] psv_q;
  logic             halt_q, imode_q, spare_q;
  logic [CNT_W-1:0] cnt_q, cnt_d, ivl_q;
  logic [ST_W-1:0]  sta_q, sta_d, ien_q;
  logic             restart, adv, evt_ivl, evt_ovf;

  assign restart = wr_cnt && wdata[CC_RESTART];

  always_ff @(posedge clk) begin
    if (rst) begin
      pre_en_q <= 1'b0;
      psv_q    <= '0;
      src_q    <= 1'b0;
      halt_q   <= 1'b1;
      imode_q  <= 1'b0;
      spare_q  <= 1'b1;
      ivl_q    <= '0;
      ien_q    <= '0;
    end else begin
      if (wr_clk) begin
        pre_en_q <= wdata[0];
        psv_q    <= wdata[PSV_W:1];
        src_q    <= wdata[PSV_W+1];
      end
      if (wr_cnt) begin
        halt_q  <= wdata[CC_HALT];
        imode_q <= wdata[CC_IMODE];
        spare_q <= wdata[CC_SPARE];
      end
      if (wr_ivl) ivl_q <= wdata;
      if (wr_ien) ien_q <= wdata[ST_W-1:0];
    end
  end

  trio_prescale #(.PSV_W(PSV_W)) u_pre (
    .clk(clk), .rst(rst), .clear(restart), .run(!halt_q),
    .tick_a(tick_a), .tick_b(tick_b), .src_sel(src_q),
    .pre_en(pre_en_q), .psv(psv_q), .adv(adv)
  );

  always_comb begin
    cnt_d   = cnt_q;
    evt_ivl = 1'b0;
    evt_ovf = 1'b0;
    if (restart) begin
      cnt_d = '0;
    end else if (adv) begin
      if (imode_q) begin
        if (ivl_q == '0) begin
          cnt_d = '0;
        end else if (cnt_q >= ivl_q) begin
          cnt_d   = '0;
          evt_ivl = 1'b1;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end else begin
        cnt_d   = cnt_q + 1'b1;
        evt_ovf = &cnt_q;
      end
    end
    sta_d = rd_sta ? '0 : sta_q;
    sta_d[ST_IVL] = sta_d[ST_IVL] | evt_ivl;
    sta_d[ST_OVF] = sta_d[ST_OVF] | evt_ovf;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      sta_q <= '0;
    end else begin
      cnt_q <= cnt_d;
      sta_q <= sta_d;
    end
  end

  assign clk_rb = {src_q, psv_q, pre_en_q};
  assign cnt_rb = {spare_q, 3'b000, imode_q, halt_q};
  assign count  = cnt_q;
  assign ivl    = ivl_q;
  assign sta    = sta_q;
  assign ien    = ien_q;
  assign irq    = |(sta_q & ien_q);

  a_r5_halt_holds: assert property (@(posedge clk) disable iff (rst)
    (halt_q && !restart) |=> $stable(cnt_q));
  a_r6_restart_zero: assert property (@(posedge clk) disable iff (rst)
    restart |=> (cnt_q == '0));
  a_r7_wrap_flags: assert property (@(posedge clk) disable iff (rst)
    (!imode_q && adv && !restart && (&cnt_q)) |=> (cnt_q == '0) && sta_q[ST_OVF]);
  a_r8_zero_interval: assert property (@(posedge clk) disable iff (rst)
    (imode_q && (ivl_q == '0) && adv && !restart) |=> (cnt_q == '0));
  a_r9_read_clears: assert property (@(posedge clk) disable iff (rst)
    (rd_sta && !evt_ivl && !evt_ovf) |=> (sta_q == '0));
endmodule

// File: rtl/trio_timer.sv
module trio_timer
  import trio_timer_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int PSV_W  = 4,
  parameter int NUM_CH = 3,
  parameter int ADDR_W = 5,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_a,
  input  logic              tick_b,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic [NUM_CH-1:0] irq
);
  localparam int CLK_W = PSV_W + 2;

  logic [CLK_W-1:0] clk_rb [NUM_CH];
  logic [5:0]       cnt_rb [NUM_CH];
  logic [CNT_W-1:0] val_rb [NUM_CH];
  logic [CNT_W-1:0] ivl_rb [NUM_CH];
  logic [ST_W-1:0]  sta_rb [NUM_CH];
  logic [ST_W-1:0]  ien_rb [NUM_CH];
  logic [DATA_W-1:0] rd_mux;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    localparam logic [ADDR_W-1:0] A_CLK = ADDR_W'(GRP_CLK + c);
    localparam logic [ADDR_W-1:0] A_CNT = ADDR_W'(GRP_CNT + c);
    localparam logic [ADDR_W-1:0] A_IVL = ADDR_W'(GRP_IVL + c);
    localparam logic [ADDR_W-1:0] A_STA = ADDR_W'(GRP_STA + c);
    localparam logic [ADDR_W-1:0] A_IEN = ADDR_W'(GRP_IEN + c);

    trio_channel #(.CNT_W(CNT_W), .PSV_W(PSV_W)) u_ch (
      .clk(clk), .rst(rst), .tick_a(tick_a), .tick_b(tick_b),
      .wr_clk(wr_en && addr == A_CLK),
      .wr_cnt(wr_en && addr == A_CNT),
      .wr_ivl(wr_en && addr == A_IVL),
      .wr_ien(wr_en && addr == A_IEN),
      .rd_sta(rd_en && addr == A_STA),
      .wdata(wdata[CNT_W-1:0]),
      .clk_rb(clk_rb[c]), .cnt_rb(cnt_rb[c]), .count(val_rb[c]),
      .ivl(ivl_rb[c]), .sta(sta_rb[c]), .ien(ien_rb[c]), .irq(irq[c])
    );
  end

  always_comb begin
    rd_mux = '0;
    for (int c = 0; c < NUM_CH; c++) begin
      if (addr == ADDR_W'(GRP_CLK + c)) rd_mux = DATA_W'(clk_rb[c]);
      if (addr == ADDR_W'(GRP_CNT + c)) rd_mux = DATA_W'(cnt_rb[c]);
      if (addr == ADDR_W'(GRP_VAL + c)) rd_mux = DATA_W'(val_rb[c]);
      if (addr == ADDR_W'(GRP_IVL + c)) rd_mux = DATA_W'(ivl_rb[c]);
      if (addr == ADDR_W'(GRP_STA + c)) rd_mux = DATA_W'(sta_rb[c]);
      if (addr == ADDR_W'(GRP_IEN + c)) rd_mux = DATA_W'(ien_rb[c]);
    end
  end

  always_ff @(posedge clk) begin
    if (rst || !rd_en) rdata <= '0;
    else               rdata <= rd_mux;
  end

  // R12: no read strobe, no data on the bus
  a_r12_idle_zero: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> (rdata == '0));
endmodule

// File: tb/trio_timer_test.sv
module trio_timer_test;
  localparam int CW = 8;
  localparam int A_CLK = 0, A_CNT = 3, A_VAL = 6, A_IVL = 9, A_STA = 21, A_IEN = 24;

  logic        clk = 1'b0, rst = 1'b1;
  logic        tick_a = 1'b0, tick_b = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
  logic [4:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [2:0]  irq;
  int checks = 0, errors = 0;
  bit done = 0;

  trio_timer #(.CNT_W(CW)) uut (
    .clk(clk), .rst(rst), .tick_a(tick_a), .tick_b(tick_b), .wr_en(wr_en),
    .rd_en(rd_en), .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq)
  );

  always #2 clk = ~clk;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(int a, logic [31:0] d);
    @(negedge clk); wr_en = 1; addr = 5'(a); wdata = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(int a, output logic [31:0] d);
    @(negedge clk); rd_en = 1; addr = 5'(a);
    @(negedge clk); d = rdata; rd_en = 0;
  endtask

  task automatic ticks(int n, bit use_b);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick_a = !use_b; tick_b = use_b;
    end
    @(negedge clk); tick_a = 0; tick_b = 0;
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    int kl[4] = '{1, 2, 7, 19};
    repeat (3) @(negedge clk);
    rst = 0;
    // R2 reset state on every channel
    for (int c = 0; c < 3; c++) begin
      rd(A_CLK + c, d); chk("R2 clk setup", d, 0);
      rd(A_CNT + c, d); chk("R2 counter control", d, 32'h21);
      rd(A_VAL + c, d); chk("R2 count", d, 0);
      rd(A_IVL + c, d); chk("R2 interval", d, 0);
      rd(A_STA + c, d); chk("R2 status", d, 0);
      rd(A_IEN + c, d); chk("R2 enable", d, 0);
    end
    chk("R2 irq", 32'(irq), 0);

    for (int c = 0; c < 3; c++) begin
      ticks(5, 0); rd(A_VAL + c, d); chk("R5 halted at reset", d, 0);
      // R3 direct counting sweep
      foreach (kl[i]) begin
        wr(A_CNT + c, 32'h10); ticks(kl[i], 0);
        rd(A_VAL + c, d); chk("R3 direct count", d, 32'(kl[i]));
      end
      // R5 halt and resume
      wr(A_CNT + c, 32'h01); ticks(4, 0);
      rd(A_VAL + c, d); chk("R5 hold", d, 19);
      wr(A_CNT + c, 32'h00); ticks(3, 0);
      rd(A_VAL + c, d); chk("R5 resume", d, 22);
      // R6 / R11 restart bit not stored, bit 5 stored
      wr(A_CNT + c, 32'h30);
      rd(A_CNT + c, d); chk("R6 R11 control readback", d, 32'h20);
      rd(A_VAL + c, d); chk("R6 restart zero", d, 0);
      ticks(3, 0); rd(A_VAL + c, d); chk("R11 spare bit no effect", d, 3);
      // R3 prescaler sweep
      for (int n = 0; n < 4; n++) begin
        wr(A_CLK + c, 32'((n << 1) | 1)); wr(A_CNT + c, 32'h10); ticks(37, 0);
        rd(A_VAL + c, d); chk("R3 prescaled count", d, 32'(37 >> (n + 1)));
      end
      // R6 restart clears prescaler phase (divide by 4)
      wr(A_CLK + c, 32'h03); wr(A_CNT + c, 32'h10); ticks(3, 0);
      wr(A_CNT + c, 32'h10); ticks(3, 0);
      rd(A_VAL + c, d); chk("R6 phase cleared", d, 0);
      ticks(1, 0); rd(A_VAL + c, d); chk("R6 phase after 4", d, 1);
      // R4 source select
      wr(A_CLK + c, 32'h20); wr(A_CNT + c, 32'h10); ticks(5, 0);
      rd(A_VAL + c, d); chk("R4 tick_a ignored", d, 0);
      ticks(6, 1); rd(A_VAL + c, d); chk("R4 tick_b counts", d, 6);
      wr(A_CLK + c, 32'h00);
      rd(A_CLK + c, d); chk("R1 clk setup readback", d, 0);
      // R11 read-only registers
      wr(A_VAL + c, 32'h55); rd(A_VAL + c, d); chk("R11 count write ignored", d, 6);
      wr(A_STA + c, 32'hF);  rd(A_STA + c, d); chk("R11 status write ignored", d, 0);
      // R8 interval sweep and R9 clear
      for (int v = 1; v <= 4; v++) begin
        wr(A_IVL + c, 32'(v)); wr(A_CNT + c, 32'h12); ticks(11, 0);
        rd(A_VAL + c, d); chk("R8 interval count", d, 32'(11 % (v + 1)));
        rd(A_STA + c, d); chk("R8 interval event", d, 1);
        rd(A_STA + c, d); chk("R9 status cleared", d, 0);
      end
      wr(A_IVL + c, 0); wr(A_CNT + c, 32'h12); ticks(5, 0);
      rd(A_VAL + c, d); chk("R8 zero interval count", d, 0);
      rd(A_STA + c, d); chk("R8 zero interval no event", d, 0);
      // R7 overflow and R10 interrupt
      wr(A_CNT + c, 32'h10); wr(A_IEN + c, 32'h8); ticks(255, 0);
      chk("R10 irq low before wrap", 32'(irq), 0);
      rd(A_VAL + c, d); chk("R7 count at max", d, 255);
      ticks(1, 0);
      chk("R10 irq on overflow", 32'(irq), 32'(1 << c));
      rd(A_VAL + c, d); chk("R7 wrapped", d, 0);
      rd(A_STA + c, d); chk("R7 overflow flag", d, 8);
      chk("R9 irq after clear", 32'(irq), 0);
      wr(A_IEN + c, 0); ticks(256, 0);
      chk("R10 masked irq", 32'(irq), 0);
      rd(A_STA + c, d); chk("R10 masked status", d, 8);
      // R9 event coinciding with the clearing read
      wr(A_IVL + c, 1); wr(A_IEN + c, 1); wr(A_CNT + c, 32'h12); ticks(2, 0);
      rd(A_STA + c, d); chk("R9 first event", d, 1);
      ticks(1, 0);
      @(negedge clk); rd_en = 1; addr = 5'(A_STA + c); tick_a = 1;
      @(negedge clk); d = rdata; rd_en = 0; tick_a = 0;
      chk("R9 read before event", d, 0);
      chk("R9 irq kept", 32'(irq), 32'(1 << c));
      rd(A_STA + c, d); chk("R9 event survived", d, 1);
      wr(A_CNT + c, 32'h01); wr(A_IEN + c, 0);
      for (int j = c + 1; j < 3; j++) begin
        rd(A_VAL + j, d); chk("R1 other channel untouched", d, 0);
      end
    end
    // R12 unmapped addresses
    rd(12, d); chk("R12 unmapped", d, 0);
    rd(20, d); chk("R12 unmapped", d, 0);
    rd(31, d); chk("R12 unmapped", d, 0);
    @(negedge clk); chk("R12 idle rdata", rdata, 0);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule